// File: doc/BRIEF.md
# Disk Controller Host-DMA Command Sequencer

This block sits between the control processor of a hard-disk controller and the host DMA/FIFO path. A `go` pulse starts a command. The sequencer checks the FIFO error line, then reads one word from the host command block at byte offset 12. If the high byte of that word is the marker value 0xFF, it fetches the eight command bytes as four single-word transfers. It then holds them on `cmd_bytes` for the decoder. If the marker is absent, it goes back to idle without any further action.

While a command runs, the decoder can ask for block transfers in either direction. When it reports completion, the sequencer writes a four-byte status block back to the host as two words. It then issues the host-interrupt state code and waits for an acknowledge. Every DMA setup is a series of writes of a state code plus a data byte. After each transfer completes, the sequencer checks the FIFO error line. On an error it clears the FIFO and repeats the transfer. If the error does not clear within `TMO_CYCLES` cycles, the command ends with a timeout error code.

Top module: `dsq_seq`

## Requirements
- R1: After reset `st_wr`, `fifo_rd` and `fifo_wr` are 0, `cmd_valid` is 0, and `host_int_n` and `ireq_n` are 1.
- R2: `go` in idle makes `ireq_n` low from the next cycle. The first transfer is three setup writes (code,data): (0xC2, 0x80), (0xC0, 0x0C), (0xDE, 0x00). Bit 7 of the 0xC2 data is the direction, and 1 means host-to-controller.
- R3: If bits 15:8 of the first word read equal 0xFF, four fetch transfers follow. Fetch k is two writes, (0xC0, 0x00) then (0xDE, k) for k = 0..3. Any other marker pops the word, returns to idle with `ireq_n` high, and raises neither `cmd_valid` nor the interrupt.
- R4: Fetched word k fills `cmd_bytes[63-16k -: 16]`, so its high (even) byte is command byte 2k. `cmd_valid` rises after the fourth word is popped.
- R5: `blk_req` while a command is held issues (0xC2, {blk_dir,7'h0}), (0xC0, 0x00), (0xFE, 0x00). After completion the block accepts further requests.
- R6: After every transfer completion `fifo_err` is sampled. If it is high, one write (0xCF, 0x00) clears the FIFO. When the error drops, the same transfer is repeated from its first setup write, and fetched data is unaffected.
- R7: If `fifo_err` stays high for `TMO_CYCLES` cycles after a clear, the command ends through the status return. The error code is 0x24 and address-valid is 0. If this happens during the status return itself, the block goes straight to the interrupt.
- R8: `done_req` starts a status return of two transfers. Each is (0xC2, 0x00), (0xC0, 0x0C), (0xDE, j) followed by one `fifo_wr` pulse. Word 0 is {valid, err[6:0], lun[2:0], lba[20:16]} and word 1 is lba[15:0].
- R9: The address-valid bit (word 0 bit 15) equals `done_disk`.
- R10: After the second status word the block writes (0xBF, 0x00). From the next cycle `host_int_n` is low and `ireq_n` is high.
- R11: `host_int_n` stays low until `int_ack`. While it is low, `go` is ignored and no setup write occurs.
- R12: At most one of `st_wr`, `fifo_rd`, `fifo_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a new command (taken in idle only) |
| int_ack | input | 1 | Acknowledge of the host interrupt |
| st_wr | output | 1 | DMA state register write strobe |
| st_code | output | 8 | State code written |
| st_data | output | 8 | Data byte written with the code |
| xfer_done | input | 1 | One-cycle pulse: DMA transfer finished |
| fifo_err | input | 1 | FIFO error status |
| fifo_rd | output | 1 | Pop the word on `fifo_rdata` |
| fifo_rdata | input | 16 | FIFO output word, even byte in bits 15:8 |
| fifo_wr | output | 1 | Push `fifo_wdata` into the FIFO |
| fifo_wdata | output | 16 | Status word being pushed |
| cmd_valid | output | 1 | Command bytes are held |
| cmd_bytes | output | 64 | Fetched command, byte 0 in bits 63:56 |
| blk_req | input | 1 | Request a block transfer |
| blk_dir | input | 1 | Block direction (1 = host to controller) |
| done_req | input | 1 | Command finished, return status |
| done_err | input | 7 | Error code for the status block |
| done_disk | input | 1 | The command accessed the disk |
| done_lun | input | 3 | Logical unit number |
| done_lba | input | 21 | Logical block address |
| host_int_n | output | 1 | Host interrupt, active low |
| ireq_n | output | 1 | Request line, low while a command runs |

## Verification
The assertions assume the following about the environment:
- `xfer_done` pulses only after a transfer has been set up.
- `done_req` and `blk_req` arrive only while a command is held.
- `int_ack` arrives only while the interrupt is pending.

The bench DMA model enforces the first assumption: it answers each 0xDE or 0xFE write with exactly one `xfer_done` pulse a fixed number of cycles later. The bench drives the request and acknowledge inputs only after it has seen `cmd_valid` or a low `host_int_n`. The model raises `fifo_err` only together with a completion pulse. It drops the error either after a hold count or on the next transfer setup, so every injected error produces exactly one clear-and-retry or one timeout.

// File: rtl/dsq_pkg.sv
`timescale 1ns/1ps
package dsq_pkg;
    localparam int CMD_WORDS  = 4;
    localparam int STAT_WORDS = 2;
    localparam int LUN_W      = 3;
    localparam int LBA_W      = 21;
    localparam int IDX_W      = $clog2(CMD_WORDS);
    localparam int CMD_W      = 16 * CMD_WORDS;

    localparam logic [7:0] ST_ADDR_HI = 8'hC2;
    localparam logic [7:0] ST_ADDR_LO = 8'hC0;
    localparam logic [7:0] ST_WORD    = 8'hDE;
    localparam logic [7:0] ST_BLOCK   = 8'hFE;
    localparam logic [7:0] ST_CLEAR   = 8'hCF;
    localparam logic [7:0] ST_HOSTINT = 8'hBF;
    localparam logic [7:0] MARKER     = 8'hFF;
    localparam logic [7:0] MARK_OFS   = 8'h0C;
    localparam logic [6:0] TMO_ERR    = 7'h24;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_SETUP, S_PUSH, S_WAIT, S_CHECK,
        S_CLR, S_CLR_WAIT, S_EXEC, S_INT, S_INT_WAIT
    } state_e;

    typedef enum logic [1:0] {K_MARK, K_FETCH, K_BLOCK, K_STAT} kind_e;

    typedef struct packed {
        state_e             state;
        kind_e              kind;
        logic [1:0]         step;
        logic [IDX_W-1:0]   idx;
        logic [CMD_W-1:0]   cmd;
        logic               cmd_valid;
        logic [6:0]         err;
        logic               adv;
        logic [LUN_W-1:0]   lun;
        logic [LBA_W-1:0]   lba;
        logic               bdir;
        logic               host_int_n;
        logic               ireq_n;
    } seq_t;
endpackage

// File: rtl/dsq_timer.sv
`timescale 1ns/1ps
module dsq_timer #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/dsq_setup_enc.sv
`timescale 1ns/1ps
module dsq_setup_enc
    import dsq_pkg::*;
(
    input  kind_e            kind,
    input  logic [1:0]       step,
    input  logic [IDX_W-1:0] idx,
    input  logic             bdir,
    output logic [7:0]       code,
    output logic [7:0]       data
);
    logic dir;

    always_comb begin
        unique case (kind)
            K_MARK, K_FETCH: dir = 1'b1;
            K_STAT:          dir = 1'b0;
            default:         dir = bdir;
        endcase
        code = 8'h00;
        data = 8'h00;
        unique case (step)
            2'd0: begin
                code = ST_ADDR_HI;
                data = {dir, 7'h00};
            end
            2'd1: begin
                code = ST_ADDR_LO;
                data = (kind == K_MARK || kind == K_STAT) ? MARK_OFS : 8'h00;
            end
            2'd2: begin
                code = (kind == K_BLOCK) ? ST_BLOCK : ST_WORD;
                data = 8'(idx);
            end
            default: begin
                code = 8'h00;
                data = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/dsq_stat_pack.sv
`timescale 1ns/1ps
module dsq_stat_pack
    import dsq_pkg::*;
(
    input  logic             adv,
    input  logic [6:0]       err,
    input  logic [LUN_W-1:0] lun,
    input  logic [LBA_W-1:0] lba,
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    localparam int HI_W = LBA_W - 16;

    logic [15:0] w0, w1;

    always_comb begin
        w0   = {adv, err, lun, lba[LBA_W-1 -: HI_W]};
        w1   = lba[15:0];
        word = (idx == '0) ? w0 : w1;
    end
endmodule

// File: rtl/dsq_seq.sv
`timescale 1ns/1ps
module dsq_seq
    import dsq_pkg::*;
#(
    parameter int TMO_CYCLES = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              int_ack,
    output logic              st_wr,
    output logic [7:0]        st_code,
    output logic [7:0]        st_data,
    input  logic              xfer_done,
    input  logic              fifo_err,
    output logic              fifo_rd,
    input  logic [15:0]       fifo_rdata,
    output logic              fifo_wr,
    output logic [15:0]       fifo_wdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_bytes,
    input  logic              blk_req,
    input  logic              blk_dir,
    input  logic              done_req,
    input  logic [6:0]        done_err,
    input  logic              done_disk,
    input  logic [LUN_W-1:0]  done_lun,
    input  logic [LBA_W-1:0]  done_lba,
    output logic              host_int_n,
    output logic              ireq_n
);
    localparam logic [IDX_W-1:0] FETCH_LAST = IDX_W'(CMD_WORDS - 1);
    localparam logic [IDX_W-1:0] STAT_LAST  = IDX_W'(STAT_WORDS - 1);

    seq_t q, d;
    logic tmr_clr, tmr_run, tmr_exp;
    logic rd_c;
    logic [7:0] enc_code, enc_data;
    logic [15:0] stat_word;

    dsq_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .expired(tmr_exp)
    );

    dsq_setup_enc u_enc (
        .kind(q.kind), .step(q.step), .idx(q.idx), .bdir(q.bdir),
        .code(enc_code), .data(enc_data)
    );

    dsq_stat_pack u_pack (
        .adv(q.adv), .err(q.err), .lun(q.lun), .lba(q.lba), .idx(q.idx),
        .word(stat_word)
    );

    always_comb begin
        d       = q;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        rd_c    = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (go) begin
                    d.state     = S_START;
                    d.ireq_n    = 1'b0;
                    d.cmd_valid = 1'b0;
                    d.err       = '0;
                    d.adv       = 1'b0;
                    d.lun       = '0;
                    d.lba       = '0;
                    d.kind      = K_MARK;
                    d.idx       = '0;
                    d.step      = 2'd0;
                end
            end
            S_START: begin
                d.state = fifo_err ? S_CLR : S_SETUP;
            end
            S_SETUP: begin
                if (q.step == 2'd2)
                    d.state = (q.kind == K_STAT) ? S_PUSH : S_WAIT;
                else
                    d.step = q.step + 2'd1;
            end
            S_PUSH: begin
                d.state = S_WAIT;
            end
            S_WAIT: begin
                if (xfer_done) d.state = S_CHECK;
            end
            S_CHECK: begin
                if (fifo_err) begin
                    d.state = S_CLR;
                end else begin
                    unique case (q.kind)
                        K_MARK: begin
                            rd_c = 1'b1;
                            if (fifo_rdata[15:8] == MARKER) begin
                                d.kind  = K_FETCH;
                                d.idx   = '0;
                                d.step  = 2'd1;
                                d.state = S_SETUP;
                            end else begin
                                d.state  = S_IDLE;
                                d.ireq_n = 1'b1;
                            end
                        end
                        K_FETCH: begin
                            rd_c = 1'b1;
                            d.cmd[(CMD_WORDS - 1 - int'(q.idx)) * 16 +: 16] = fifo_rdata;
                            if (q.idx == FETCH_LAST) begin
                                d.state     = S_EXEC;
                                d.cmd_valid = 1'b1;
                            end else begin
                                d.idx   = q.idx + 1'b1;
                                d.step  = 2'd1;
                                d.state = S_SETUP;
                            end
                        end
                        K_BLOCK: begin
                            d.state = S_EXEC;
                        end
                        default: begin
                            if (q.idx == STAT_LAST) begin
                                d.state = S_INT;
                            end else begin
                                d.idx   = q.idx + 1'b1;
                                d.step  = 2'd0;
                                d.state = S_SETUP;
                            end
                        end
                    endcase
                end
            end
            S_CLR: begin
                tmr_clr = 1'b1;
                d.state = S_CLR_WAIT;
            end
            S_CLR_WAIT: begin
                if (!fifo_err) begin
                    d.state = S_SETUP;
                    d.step  = (q.kind == K_FETCH) ? 2'd1 : 2'd0;
                end else if (tmr_exp) begin
                    if (q.kind == K_STAT) begin
                        d.state = S_INT;
                    end else begin
                        d.kind      = K_STAT;
                        d.idx       = '0;
                        d.step      = 2'd0;
                        d.err       = TMO_ERR;
                        d.adv       = 1'b0;
                        d.cmd_valid = 1'b0;
                        d.state     = S_SETUP;
                    end
                end else begin
                    tmr_run = 1'b1;
                end
            end
            S_EXEC: begin
                if (done_req) begin
                    d.kind      = K_STAT;
                    d.idx       = '0;
                    d.step      = 2'd0;
                    d.err       = done_err;
                    d.adv       = done_disk;
                    d.lun       = done_lun;
                    d.lba       = done_lba;
                    d.cmd_valid = 1'b0;
                    d.state     = S_SETUP;
                end else if (blk_req) begin
                    d.kind  = K_BLOCK;
                    d.idx   = '0;
                    d.step  = 2'd0;
                    d.bdir  = blk_dir;
                    d.state = S_SETUP;
                end
            end
            S_INT: begin
                d.host_int_n = 1'b0;
                d.ireq_n     = 1'b1;
                d.state      = S_INT_WAIT;
            end
            S_INT_WAIT: begin
                if (int_ack) begin
                    d.host_int_n = 1'b1;
                    d.state      = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.state      <= S_IDLE;
            q.kind       <= K_MARK;
            q.host_int_n <= 1'b1;
            q.ireq_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        st_wr   = 1'b0;
        st_code = 8'h00;
        st_data = 8'h00;
        unique case (q.state)
            S_SETUP: begin
                st_wr   = 1'b1;
                st_code = enc_code;
                st_data = enc_data;
            end
            S_CLR: begin
                st_wr   = 1'b1;
                st_code = ST_CLEAR;
            end
            S_INT: begin
                st_wr   = 1'b1;
                st_code = ST_HOSTINT;
            end
            default: ;
        endcase
    end

    assign fifo_rd    = rd_c;
    assign fifo_wr    = (q.state == S_PUSH);
    assign fifo_wdata = stat_word;
    assign cmd_valid  = q.cmd_valid;
    assign cmd_bytes  = q.cmd;
    assign host_int_n = q.host_int_n;
    assign ireq_n     = q.ireq_n;
endmodule

// File: rtl/dsq_chk.sv
`timescale 1ns/1ps
module dsq_chk
    import dsq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       int_ack,
    input logic       xfer_done,
    input logic       st_wr,
    input logic [7:0] st_code,
    input logic       fifo_rd,
    input logic       fifo_wr,
    input logic       cmd_valid,
    input logic       host_int_n,
    input logic       ireq_n
);
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_wr, fifo_rd, fifo_wr}) <= 1);

    // R11
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_int_n && !int_ack) |=> !host_int_n);

    // R11
    int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_int_n |-> !st_wr);

    // R10
    int_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_code == ST_HOSTINT) |=> (!host_int_n && ireq_n));

    // R4
    cmd_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(fifo_rd));

    // R8
    push_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(st_wr && st_code == ST_WORD));

    // R3
    pop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> $past(xfer_done));

    // R2
    ireq_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ireq_n) |-> $past(go));
endmodule

bind dsq_seq dsq_chk u_dsq_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .int_ack(int_ack),
    .xfer_done(xfer_done), .st_wr(st_wr), .st_code(st_code),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .cmd_valid(cmd_valid),
    .host_int_n(host_int_n), .ireq_n(ireq_n)
);

// File: tb/dsq_seq_test.sv
`timescale 1ns/1ps
module dsq_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, int_ack = 1'b0;
    logic st_wr;
    logic [7:0] st_code, st_data;
    logic xfer_done = 1'b0, fifo_err = 1'b0;
    logic fifo_rd, fifo_wr;
    logic [15:0] fifo_rdata, fifo_wdata;
    logic cmd_valid;
    logic [63:0] cmd_bytes;
    logic blk_req = 1'b0, blk_dir = 1'b0, done_req = 1'b0, done_disk = 1'b0;
    logic [6:0] done_err = '0;
    logic [2:0] done_lun = '0;
    logic [20:0] done_lba = '0;
    logic host_int_n, ireq_n;

    always #4 clk = ~clk;

    dsq_seq #(.TMO_CYCLES(50)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .int_ack(int_ack),
        .st_wr(st_wr), .st_code(st_code), .st_data(st_data),
        .xfer_done(xfer_done), .fifo_err(fifo_err),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .cmd_valid(cmd_valid), .cmd_bytes(cmd_bytes),
        .blk_req(blk_req), .blk_dir(blk_dir), .done_req(done_req),
        .done_err(done_err), .done_disk(done_disk), .done_lun(done_lun),
        .done_lba(done_lba), .host_int_n(host_int_n), .ireq_n(ireq_n)
    );

    // DMA / FIFO model
    logic [15:0] rq [256];
    logic [7:0]  rd_idx = '0;
    logic [7:0]  code_log [512];
    logic [7:0]  data_log [512];
    logic [15:0] wlog [64];
    int nlog = 0, nw = 0, xfer_cnt = 0, pend = 0;
    int err_at = 1000000, err_hold = 0, err_left = 0;

    assign fifo_rdata = rq[rd_idx];

    always @(posedge clk) if (fifo_rd) rd_idx <= rd_idx + 8'd1;

    always @(negedge clk) begin
        xfer_done <= 1'b0;
        if (st_wr) begin
            code_log[nlog[8:0]] = st_code;
            data_log[nlog[8:0]] = st_data;
            nlog = nlog + 1;
            if (st_code == 8'hDE || st_code == 8'hFE) begin
                xfer_cnt = xfer_cnt + 1;
                pend = 3;
                fifo_err <= 1'b0;
                err_left = 0;
            end
        end
        if (fifo_wr) begin
            wlog[nw[5:0]] = fifo_wdata;
            nw = nw + 1;
        end
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                xfer_done <= 1'b1;
                if (xfer_cnt - 1 == err_at) begin
                    fifo_err <= 1'b1;
                    err_left = err_hold;
                end
            end
        end else if (err_left > 0) begin
            err_left = err_left - 1;
            if (err_left == 0) fifo_err <= 1'b0;
        end
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_wr(input string req, input int pos, input logic [7:0] c, input logic [7:0] dv);
        chk(req, {48'h0, code_log[pos[8:0]], data_log[pos[8:0]]}, {48'h0, c, dv});
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_cmd();
        for (int i = 0; i < 400 && !cmd_valid; i++) @(negedge clk);
    endtask

    task automatic wait_int();
        for (int i = 0; i < 800 && host_int_n; i++) @(negedge clk);
    endtask

    task automatic load_cmd(input logic [15:0] mk, input logic [63:0] w);
        rq[rd_idx] = mk;
        for (int k = 0; k < 4; k++) rq[rd_idx + 8'(k + 1)] = w[63 - 16*k -: 16];
    endtask

    task automatic pulse_go();
        go = 1'b1; @(negedge clk); go = 1'b0;
    endtask

    task automatic ack_int();
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        chk("R11 released", {63'h0, host_int_n}, 64'h1);
    endtask

    typedef struct packed {
        logic [15:0] marker;
        logic [63:0] words;
        logic [6:0]  err;
        logic        disk;
        logic [2:0]  lun;
        logic [20:0] lba;
        logic [1:0]  blk;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{16'hFF3C, 64'h0123_4567_89AB_CDEF, 7'h00, 1'b1, 3'd5, 21'h1A2B3C, 2'b00},
        '{16'hFF00, 64'hFFFF_0000_A5A5_5A5A, 7'h11, 1'b0, 3'd2, 21'h00F0F0, 2'b11},
        '{16'hFFFF, 64'h8000_0001_7FFE_1234, 7'h7F, 1'b1, 3'd7, 21'h1FFFFF, 2'b10}
    };

    task automatic run_vec(input vec_t v);
        int lg0, lg1, lgb, w0;
        load_cmd(v.marker, v.words);
        lg0 = nlog;
        pulse_go();
        chk("R2 ireq low", {63'h0, ireq_n}, 64'h0);
        wait_cmd();
        chk("R4 cmd bytes", cmd_bytes, v.words);
        chk_wr("R2 addr hi", lg0, 8'hC2, 8'h80);
        chk_wr("R2 addr lo", lg0 + 1, 8'hC0, 8'h0C);
        chk_wr("R2 word", lg0 + 2, 8'hDE, 8'h00);
        for (int k = 0; k < 4; k++) begin
            chk_wr("R3 fetch lo", lg0 + 3 + 2*k, 8'hC0, 8'h00);
            chk_wr("R3 fetch word", lg0 + 4 + 2*k, 8'hDE, 8'(k));
        end
        if (v.blk[1]) begin
            lgb = nlog;
            blk_dir = v.blk[0]; blk_req = 1'b1; @(negedge clk); blk_req = 1'b0;
            cyc(12);
            chk_wr("R5 blk hi", lgb, 8'hC2, {v.blk[0], 7'h00});
            chk_wr("R5 blk lo", lgb + 1, 8'hC0, 8'h00);
            chk_wr("R5 blk mode", lgb + 2, 8'hFE, 8'h00);
            chk("R5 still held", {63'h0, cmd_valid}, 64'h1);
        end
        lg1 = nlog; w0 = nw;
        done_err = v.err; done_disk = v.disk; done_lun = v.lun; done_lba = v.lba;
        done_req = 1'b1; @(negedge clk); done_req = 1'b0;
        wait_int();
        chk("R8 word0", {48'h0, wlog[w0[5:0]]}, {48'h0, v.disk, v.err, v.lun, v.lba[20:16]});
        chk("R9 valid bit", {63'h0, wlog[w0[5:0]][15]}, {63'h0, v.disk});
        chk("R8 word1", {48'h0, wlog[w0[5:0] + 6'd1]}, {48'h0, v.lba[15:0]});
        for (int j = 0; j < 2; j++) begin
            chk_wr("R8 stat hi", lg1 + 3*j, 8'hC2, 8'h00);
            chk_wr("R8 stat lo", lg1 + 3*j + 1, 8'hC0, 8'h0C);
            chk_wr("R8 stat word", lg1 + 3*j + 2, 8'hDE, 8'(j));
        end
        chk_wr("R10 int code", lg1 + 6, 8'hBF, 8'h00);
        chk("R10 ireq high", {63'h0, ireq_n}, 64'h1);
        lg0 = nlog;
        pulse_go();
        cyc(10);
        chk("R11 go ignored", 64'(nlog - lg0), 64'h0);
        chk("R11 int held", {63'h0, host_int_n}, 64'h0);
        ack_int();
        cyc(2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int lg0, de_cnt, clr_cnt;
        cyc(3);
        chk("R1 reset outs", {58'h0, st_wr, fifo_rd, fifo_wr, cmd_valid, host_int_n, ireq_n}, 64'h3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 after release", {58'h0, st_wr, fifo_rd, fifo_wr, cmd_valid, host_int_n, ireq_n}, 64'h3);

        for (int i = 0; i < 3; i++) run_vec(VECS[i]);

        // R3: marker absent
        load_cmd(16'h12FF, 64'h0);
        lg0 = nlog;
        pulse_go();
        cyc(30);
        chk("R3 no marker writes", 64'(nlog - lg0), 64'd3);
        chk("R3 no marker state", {61'h0, cmd_valid, ireq_n, host_int_n}, 64'h3);

        // R6: error on fetch word 1, recovered
        load_cmd(16'hFF00, 64'hDEAD_BEEF_CAFE_F00D);
        lg0 = nlog;
        err_at = xfer_cnt + 2; err_hold = 3;
        pulse_go();
        wait_cmd();
        err_at = 1000000;
        chk("R6 cmd intact", cmd_bytes, 64'hDEAD_BEEF_CAFE_F00D);
        de_cnt = 0; clr_cnt = 0;
        for (int p = lg0; p < nlog; p++) begin
            if (code_log[p[8:0]] == 8'hDE) de_cnt++;
            if (code_log[p[8:0]] == 8'hCF) clr_cnt++;
        end
        chk("R6 word transfers", 64'(de_cnt), 64'd6);
        chk("R6 clear writes", 64'(clr_cnt), 64'd1);
        done_err = 7'h00; done_disk = 1'b0; done_lun = '0; done_lba = '0;
        done_req = 1'b1; @(negedge clk); done_req = 1'b0;
        wait_int();
        ack_int();
        cyc(2);

        // R7: error never clears on fetch word 0
        load_cmd(16'hFF00, 64'h1111_2222_3333_4444);
        lg0 = nw;
        err_at = xfer_cnt + 1; err_hold = 100000;
        pulse_go();
        wait_int();
        err_at = 1000000;
        chk("R7 timeout word0", {48'h0, wlog[lg0[5:0]]}, 64'h2400);
        chk("R7 timeout word1", {48'h0, wlog[lg0[5:0] + 6'd1]}, 64'h0);
        chk("R7 no command", {63'h0, cmd_valid}, 64'h0);
        ack_int();
        cyc(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule